// File: doc/BRIEF.md
# Alternating-Turn Obstacle Steering Controller

This block steers a mobile platform from a single obstacle-sensor bit. While the path is clear it commands no turn. When an obstacle appears it commands a turn, and it keeps the same turn for as long as the obstacle stays. It remembers which way it turned last, through any number of clear cycles, so that each new obstacle is taken in the opposite direction from the one before.

The machine is a Mealy machine with four states held in a two-bit register. The state code is Gray-ordered: the idle state after a left turn is 00, turning right is 01, the idle state after a right turn is 11, and turning left is 10. The turn command comes straight from combinational logic on the state and the sensor bit, so it follows the sensor within the same cycle. A synchronous, active-high clear puts the machine in the idle-after-left state, so the first obstacle after clear is taken to the right. The sensor and the command are plain level signals with no handshake: the sensor is sampled on every clock edge and nothing can hold it off.

Top module: `turn_alternator`

## Requirements
- R1: When `clear` is 1 at a rising clock edge, the state becomes 00 (idle, last turn left). The first obstacle after that edge gives `steer` = 01 (right).
- R2: From idle-after-left (00), `obstacle` = 1 gives `steer` = 01 (right) and moves the state to turning right (01).
- R3: While the obstacle is held in a turning state, `steer` keeps the same nonzero value on every cycle and the state does not change.
- R4: Whenever `obstacle` = 0, `steer` = 00 (no turn). The first clear cycle after an obstacle moves a turning state to the idle state that records that turn: 01 goes to 11 and 10 goes to 00.
- R5: From idle-after-right (11), `obstacle` = 1 gives `steer` = 10 (left) and moves the state to turning left (10).
- R6: Consecutive obstacle episodes alternate their turn direction, whatever the number of clear cycles between them.
- R7: `steer` never takes the value 11.
- R8: `steer` is combinational from the state and `obstacle`. A change of `obstacle` within a cycle shows on `steer` before the next clock edge.
- R9: In an idle state, `obstacle` = 0 holds the state, so the remembered direction survives clear stretches of any length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state updates on the rising edge |
| clear | input | 1 | Synchronous active-high clear to idle-after-left (00) |
| obstacle | input | 1 | 1 = obstacle present, 0 = path clear |
| steer | output | 2 | Turn command: 00 none, 01 right, 10 left; 11 never driven |

## Verification
On every cycle the assertions check that 11 never appears on `steer`, that a clear path always gives no turn, that a held obstacle repeats the previous command, that each newly risen obstacle turns away from the last recorded turn, that clear lands in state 00, and that a clear cycle always leaves the machine in an idle state. The bench's scenarios are what show the same-cycle response of `steer` to a mid-cycle change of the sensor, the right turn as the first turn after a clear given in the middle of a left turn, and the memory of the direction across long clear stretches. Its reference model covers every cycle of those scenarios.

// File: rtl/turn_pkg.sv
package turn_pkg;
  localparam int STATE_W = 2;
  localparam int CMD_W   = 2;

  // Gray-ordered state code
  typedef enum logic [STATE_W-1:0] {
    ST_IDLE_LEFT  = 2'b00,  // path clear, last turn was left
    ST_GO_RIGHT   = 2'b01,  // obstacle present, turning right
    ST_IDLE_RIGHT = 2'b11,  // path clear, last turn was right
    ST_GO_LEFT    = 2'b10   // obstacle present, turning left
  } nav_state_t;

  localparam logic [CMD_W-1:0] CMD_NONE  = 2'b00;
  localparam logic [CMD_W-1:0] CMD_RIGHT = 2'b01;
  localparam logic [CMD_W-1:0] CMD_LEFT  = 2'b10;

  localparam nav_state_t START_STATE = ST_IDLE_LEFT;
endpackage

// File: rtl/nav_state_reg.sv
module nav_state_reg
  import turn_pkg::*;
(
  input  logic       clk,
  input  logic       clear,
  input  nav_state_t next_state,
  output nav_state_t state
);
  always_ff @(posedge clk) begin
    if (clear) state <= START_STATE;
    else       state <= next_state;
  end
endmodule

// File: rtl/nav_next_state.sv
module nav_next_state
  import turn_pkg::*;
(
  input  nav_state_t state,
  input  logic       obstacle,
  output nav_state_t next_state
);
  always_comb begin
    next_state = state;
    unique case (state)
      ST_IDLE_LEFT:  next_state = obstacle ? ST_GO_RIGHT : ST_IDLE_LEFT;
      ST_GO_RIGHT:   next_state = obstacle ? ST_GO_RIGHT : ST_IDLE_RIGHT;
      ST_IDLE_RIGHT: next_state = obstacle ? ST_GO_LEFT  : ST_IDLE_RIGHT;
      ST_GO_LEFT:    next_state = obstacle ? ST_GO_LEFT  : ST_IDLE_LEFT;
      default:       next_state = START_STATE;
    endcase
  end
endmodule

// File: rtl/nav_cmd_decode.sv
module nav_cmd_decode
  import turn_pkg::*;
(
  input  nav_state_t       state,
  input  logic             obstacle,
  output logic [CMD_W-1:0] steer
);
  always_comb begin
    steer = CMD_NONE;
    if (obstacle) begin
      unique case (state)
        ST_IDLE_LEFT, ST_GO_RIGHT: steer = CMD_RIGHT;
        ST_IDLE_RIGHT, ST_GO_LEFT: steer = CMD_LEFT;
        default:                   steer = CMD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/turn_alternator.sv
module turn_alternator
  import turn_pkg::*;
(
  input  logic             clk,
  input  logic             clear,
  input  logic             obstacle,
  output logic [CMD_W-1:0] steer
);
  nav_state_t state_q;
  nav_state_t state_d;

  nav_state_reg u_reg (
    .clk        (clk),
    .clear      (clear),
    .next_state (state_d),
    .state      (state_q)
  );

  nav_next_state u_next (
    .state      (state_q),
    .obstacle   (obstacle),
    .next_state (state_d)
  );

  nav_cmd_decode u_cmd (
    .state    (state_q),
    .obstacle (obstacle),
    .steer    (steer)
  );
endmodule

// File: rtl/turn_alternator_checker.sv
module turn_alternator_checker
  import turn_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             blocked,
  input logic [CMD_W-1:0] steer,
  input logic [STATE_W-1:0] state
);
  logic [CMD_W-1:0] last_turn_q;
  logic             seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_turn_q <= CMD_NONE;
      seen_q      <= 1'b0;
    end else if (steer != CMD_NONE) begin
      last_turn_q <= steer;
      seen_q      <= 1'b1;
    end
  end

  assert_no_code11_R7: assert property (@(posedge clk) disable iff (rst)
    steer != 2'b11);

  assert_clear_start_R1: assert property (@(posedge clk)
    rst |=> state == 2'b00);

  assert_hold_repeat_R3: assert property (@(posedge clk) disable iff (rst)
    (blocked && $past(blocked) && !$past(rst)) |-> (steer == $past(steer)));

  assert_idle_no_turn_R4: assert property (@(posedge clk) disable iff (rst)
    !blocked |-> steer == CMD_NONE);

  assert_alternate_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(blocked) && seen_q) |-> (steer != last_turn_q && steer != CMD_NONE));

  assert_clear_lands_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !blocked |=> (state == 2'b00 || state == 2'b11));
endmodule

bind turn_alternator turn_alternator_checker u_chk (
  .clk     (clk),
  .rst     (clear),
  .blocked (obstacle),
  .steer   (steer),
  .state   (state_q)
);

// File: tb/turn_alternator_bench.sv
module turn_alternator_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       clear = 1'b1;
  logic       obstacle = 1'b0;
  logic [1:0] steer;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // reference model: 1 = right, 2 = left
  int  m_last = 2;
  int  m_cur  = 0;
  bit  m_in_obs = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  turn_alternator u_turn_alternator (
    .clk      (clk),
    .clear    (clear),
    .obstacle (obstacle),
    .steer    (steer)
  );

  function automatic int model_cmd(input bit b);
    if (!b) return 0;
    if (m_in_obs) return m_cur;
    return (m_last == 1) ? 2 : 1;
  endfunction

  task automatic check(input string tag, input int exp);
    n_checks++;
    if (int'(steer) != exp) begin
      n_fail++;
      $display("FAIL %s: steer=%0d expected=%0d at %0t", tag, steer, exp, $time);
    end
  endtask

  task automatic model_edge();
    if (clear) begin
      m_last = 2; m_in_obs = 1'b0; m_cur = 0;
    end else if (obstacle) begin
      if (!m_in_obs) begin
        m_cur = (m_last == 1) ? 2 : 1;
        m_in_obs = 1'b1;
      end
    end else if (m_in_obs) begin
      m_last = m_cur;
      m_in_obs = 1'b0;
    end
  endtask

  // drive one cycle, compare with model mid-cycle, then step model at edge
  task automatic step(input bit b, input string tag);
    @(negedge clk);
    obstacle = b;
    #1;
    if (!clear) check(tag, model_cmd(b));
    @(posedge clk);
    model_edge();
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1; obstacle = 1'b0;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    clear = 1'b0;
    #1;
    check("R1 idle after clear", 0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    model_edge();
    do_clear();

    // sequence 0,1,1,0,0,1,0,1
    step(0, "R9 idle");
    step(1, "R1 R2 first obstacle right");
    step(1, "R3 held right");
    step(0, "R4 release");
    step(0, "R9 idle right");
    step(1, "R5 R6 obstacle left");
    step(0, "R4 release left");
    step(1, "R6 obstacle right again");

    // long hold then long idle
    for (int i = 0; i < 6; i++) step(1, "R3 long hold");
    for (int i = 0; i < 20; i++) step(0, "R9 long idle");
    step(1, "R6 after long idle left");
    step(1, "R3 held left");
    for (int i = 0; i < 9; i++) step(0, "R9 idle after left");
    step(1, "R6 right after left");
    step(0, "R4 release right");

    // mid-cycle sensor change on steer (combinational)
    @(negedge clk);
    obstacle = 1'b0; #1;
    check("R8 clear part of cycle", 0);
    obstacle = 1'b1; #1;
    check("R8 same-cycle left", 2);
    obstacle = 1'b0; #1;
    check("R8 back to none", 0);
    @(posedge clk);
    model_edge();
    step(0, "R9 still idle right");

    // clear in the middle of a left turn
    step(1, "R5 left before clear");
    step(1, "R3 left held");
    do_clear();
    step(1, "R1 first after clear right");
    step(1, "R3 right held");
    step(0, "R4 release");
    step(1, "R5 left");
    step(0, "R4 release");

    // alternating rapid pattern
    for (int i = 0; i < 10; i++) step(i[0], "R6 rapid alternation");
    for (int i = 0; i < 8; i++) step((i % 3) != 0, "R7 mixed pattern");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  // per-edge check that code 11 never appears
  always @(negedge clk) begin
    if (!clear && steer == 2'b11) begin
      n_checks++; n_fail++;
      $display("FAIL R7: steer=%0d expected not 3", steer);
    end
  end
endmodule